// File: doc/BRIEF.md
# Decimal Digit Sequence Detector

This block watches a stream of decimal digits, one 4-bit BCD code per clock cycle. It raises a single flag in the cycle where the current digit, together with the three digits before it, spells out 1, 5, 5, 7. The oldest of the four digits is the 1 and the current digit is the 7.

The three previous digits are held in a short shift chain that advances on every rising clock edge. Each stage is compared with its fixed target digit, and so is the live input, all without registers. The flag is therefore valid in the same cycle that the closing 7 is on the input. There is no enable, so every cycle consumes a digit. Codes 10 to 15 pass through the chain like any other value, but they never equal a target digit.

Top module: `digit_seq_detect`

## Requirements
- R1: While `rst` is high at a rising edge, all three history stages are loaded with 0. In the cycle after that edge, `hit` stays 0 for any `digit_in`, including 7.
- R2: `hit` is 1 in the same cycle that `digit_in` is 7, provided the digits presented in the three previous cycles were 1, then 5, then 5 (oldest first).
- R3: In every cycle that does not meet the condition in R2, `hit` is 0.
- R4: The history advances by exactly one digit at each rising edge, with no enable. Holding 7 for a second cycle after a match gives `hit` = 0 in that second cycle.
- R5: Back-to-back patterns are each detected. The stream 1,5,5,7,1,5,5,7 gives two single-cycle pulses four cycles apart.
- R6: Input codes 10 to 15 never match a pattern position. Such a code, whether current or stored, prevents `hit`.
- R7: A reset applied in the middle of a pattern discards the partial history. The stream 1,5,5, reset, 7 gives `hit` = 0.
- R8: Order matters. The streams 5,1,5,7 and 1,5,7 do not raise `hit`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the history shifts on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| digit_in | input | W (4) | Current BCD digit |
| hit | output | 1 | High while the last four digits are 1,5,5,7 |

## Verification
`hit` has no register after the history chain. It is due in the same cycle that the final 7 is driven, once the three earlier digits have been captured by three rising edges. The bench drives each digit just after a falling edge and samples `hit` one nanosecond later, well before the next rising edge. Each check therefore sees the output for exactly the digit it applied. Reset effects are checked in the cycle after a rising edge taken with `rst` high, because that is when the cleared history first reaches the comparators.

// File: rtl/digit_seq_detect.sv
module digit_seq_detect #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] digit_in,
  output logic         hit
);
  localparam int LEN   = 4;
  localparam int DEPTH = LEN - 1;

  function automatic logic [W-1:0] target(input int pos);
    case (pos)
      0:       return W'(7);
      1:       return W'(5);
      2:       return W'(5);
      default: return W'(1);
    endcase
  endfunction

  logic [W-1:0] hist [DEPTH];
  logic [LEN-1:0] eq;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
    end else begin
      hist[0] <= digit_in;
      for (int i = 1; i < DEPTH; i++) hist[i] <= hist[i-1];
    end
  end

  assign eq[0] = (digit_in == target(0));

  generate
    for (genvar k = 1; k < LEN; k++) begin : g_cmp
      assign eq[k] = (hist[k-1] == target(k));
    end
  endgenerate

  assign hit = &eq;
endmodule

module digit_seq_detect_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] digit_in,
  input logic         hit
);
  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !hit);

  p_hit_needs_history_r2: assert property (@(posedge clk) disable iff (rst)
    hit |-> (digit_in == W'(7) && $past(digit_in) == W'(5) &&
             $past(digit_in, 2) == W'(5) && $past(digit_in, 3) == W'(1)));

  p_full_match_fires_r3: assert property (@(posedge clk) disable iff (rst)
    (digit_in == W'(7) && $past(digit_in) == W'(5) && $past(digit_in, 2) == W'(5) &&
     $past(digit_in, 3) == W'(1) && !$past(rst) && !$past(rst, 2) && !$past(rst, 3))
    |-> hit);

  p_single_cycle_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit);

  p_high_codes_block_r6: assert property (@(posedge clk) disable iff (rst)
    (digit_in > W'(9)) |-> !hit);
endmodule

bind digit_seq_detect digit_seq_detect_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .digit_in(digit_in), .hit(hit)
);

// File: tb/tb_digit_seq_detect.sv
`timescale 1ns/1ps
module tb_digit_seq_detect;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] digit_in = 4'd0;
  logic       hit;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  digit_seq_detect #(.W(4)) dut (
    .clk(clk), .rst(rst), .digit_in(digit_in), .hit(hit)
  );

  localparam int NV = 29;
  localparam logic [4:0] VEC [NV] = '{
    {4'd1,1'b0}, {4'd5,1'b0}, {4'd5,1'b0}, {4'd7,1'b1},
    {4'd1,1'b0}, {4'd5,1'b0}, {4'd5,1'b0}, {4'd7,1'b1},
    {4'd5,1'b0}, {4'd1,1'b0}, {4'd5,1'b0}, {4'd7,1'b0},
    {4'd1,1'b0}, {4'd5,1'b0}, {4'd7,1'b0},
    {4'd1,1'b0}, {4'd5,1'b0}, {4'd5,1'b0}, {4'd15,1'b0},
    {4'd1,1'b0}, {4'd5,1'b0}, {4'd11,1'b0}, {4'd7,1'b0},
    {4'd3,1'b0}, {4'd1,1'b0}, {4'd5,1'b0}, {4'd5,1'b0}, {4'd7,1'b1},
    {4'd7,1'b0}
  };

  task automatic check(input logic exp, input string tag);
    checks++;
    if (hit !== exp) begin
      errors++;
      $display("FAIL %s: hit=%0b expected=%0b (digit=%0d)", tag, hit, exp, digit_in);
    end
  endtask

  task automatic step(input logic [3:0] d, input logic exp, input string tag);
    @(negedge clk);
    digit_in = d;
    #1;
    check(exp, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: finished=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    digit_in = 4'd7;
    #1;
    check(1'b0, "R1 during reset");
    rst = 1'b0;
    step(4'd7, 1'b0, "R1 first cycle after reset");

    for (int i = 0; i < NV; i++)
      step(VEC[i][4:1], VEC[i][0], VEC[i][0] ? "R2 table match" : "R3 table no match");

    // R5: back-to-back pulses exactly four cycles apart
    do_reset();
    step(4'd1, 1'b0, "R5");
    step(4'd5, 1'b0, "R5");
    step(4'd5, 1'b0, "R5");
    step(4'd7, 1'b1, "R5 first pulse");
    step(4'd1, 1'b0, "R5 gap");
    step(4'd5, 1'b0, "R5 gap");
    step(4'd5, 1'b0, "R5 gap");
    step(4'd7, 1'b1, "R5 second pulse");

    // R4: the match does not persist while the 7 is held
    step(4'd7, 1'b0, "R4 held seven");

    // R6: every out-of-range code in the last position
    for (int c = 10; c < 16; c++) begin
      step(4'd1, 1'b0, "R6");
      step(4'd5, 1'b0, "R6");
      step(4'd5, 1'b0, "R6");
      step(4'(c), 1'b0, "R6 high code as last digit");
    end
    // R6: out-of-range code stored in the oldest position
    step(4'd12, 1'b0, "R6");
    step(4'd5, 1'b0, "R6");
    step(4'd5, 1'b0, "R6");
    step(4'd7, 1'b0, "R6 high code in history");

    // R7: reset mid-pattern discards history
    step(4'd1, 1'b0, "R7");
    step(4'd5, 1'b0, "R7");
    step(4'd5, 1'b0, "R7");
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    digit_in = 4'd7;
    #1;
    check(1'b0, "R7 seven after mid-pattern reset");

    // R8: wrong order and missing digit
    do_reset();
    step(4'd5, 1'b0, "R8");
    step(4'd1, 1'b0, "R8");
    step(4'd5, 1'b0, "R8");
    step(4'd7, 1'b0, "R8 order 5,1,5,7");
    step(4'd1, 1'b0, "R8");
    step(4'd5, 1'b0, "R8");
    step(4'd7, 1'b0, "R8 order 1,5,7");

    // R2 again after all of the above
    step(4'd1, 1'b0, "R2");
    step(4'd5, 1'b0, "R2");
    step(4'd5, 1'b0, "R2");
    step(4'd7, 1'b1, "R2 final match");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule